// File: doc/BRIEF.md
# Double-Buffered One-Shot DMA Channel

This block is one DMA channel that owns two descriptor sets. Each set holds a buffer address, a byte length and a command word. At any moment one set is the active one and the hardware works through it. Meanwhile software fills in the other set. When the active transfer ends, the channel moves its pointer to the other set. If software has armed that set, the next transfer starts without any software action in between.

Data moves in whole beats of `DATA_W` bits. In the memory-read direction, each beat is fetched over a request/grant memory port and then offered on a valid/ready output stream. In the memory-write direction, each beat is taken from a valid/ready input stream and then written through the same memory port. Completion of a set disarms that set, records which set finished, and raises a level interrupt. Software clears the interrupt by writing 1 to it. Clearing the channel enable stops the channel at the next beat boundary.

Back-pressure rules:
- Once `mem_req` is raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_gnt` is high.
- Once `out_valid` is raised, it stays high with `out_data` unchanged until `out_ready` is seen.
- An input beat is taken only in a cycle where both `in_valid` and `in_ready` are high.

Top module: `pingpong_dma`

## Requirements
- R1: After reset, every descriptor field, the control register and the status register read 0, `irq` is low, and `mem_req`, `in_ready` and `out_valid` are low.
- R2: The register offsets are as follows:
  - Set s occupies byte offset 0x10*s: address at +0x0, length at +0x4, command at +0x8. Command bit 0 is the start (arm) bit.
  - The control register is at 0x20: bit 0 is the enable, bit 1 is the direction (1 means peripheral to memory).
  - The status register is at 0x24: bit 0 is the interrupt flag, bit 1 is the set that last finished, bit 2 is the active-set pointer, bit 3 is busy.
  - Values written while the channel is idle read back unchanged.
- R3: In the read direction, each beat is a memory read at the current address. The returned word appears on `out_data`. `out_valid` holds, with the data stable, until `out_ready` is high.
- R4: In the write direction, a word accepted on the input stream is written to the current address. `mem_req` holds, with address and data stable, until `mem_gnt` is high.
- R5: The address advances by `DATA_W/8` on every granted beat and the length falls by the same amount. A set of length L (a multiple of the beat size) ends after L/(DATA_W/8) beats, leaving its address advanced and its length at 0.
- R6: On completion:
  - the finished set's start bit clears;
  - status bit 1 takes the finished set's number;
  - the interrupt flag and `irq` go high;
  - writing 1 to status bit 0 clears the flag.
- R7: After each completion the active pointer flips. If the other set is armed, its beats follow with no register access in between.
- R8: With enable set and no set armed, no memory request is made. When the set under the pointer is unarmed but the other set is armed, the pointer moves to the armed set and that set runs.
- R9: While a transfer runs, writes to the active set's address, length and command registers are ignored. Writes to the other set take effect.
- R10: Clearing the enable lets any beat already in flight finish. After that, no further requests are made, the running set's start bit clears, no interrupt is raised, and the pointer returns to set 0.
- R11: An armed set of length 0 completes as in R6 without issuing any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt, the status flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Grant; the beat completes in this cycle |
| mem_rdata | input | DATA_W | Read data, valid together with `mem_gnt` |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | Input stream ready |
| in_data | input | DATA_W | Input stream data |
| out_valid | output | 1 | Output stream valid |
| out_ready | input | 1 | Output stream ready |
| out_data | output | DATA_W | Output stream data |

## Verification
The read direction is driven with a grant on every other request and a sink that stalls every third cycle. A dropped or duplicated beat therefore shows up as a wrong address or data sequence.

The write direction is driven with both sets armed back to back. This separates a correct pointer flip from one that restarts the same set, and it confirms that no software step is needed between the two sets.

Arming only the set away from the pointer tests skipping. A zero-length set shows whether completion depends on issuing a beat. An enable drop in the middle of a long transfer shows whether the stop waits for the beat boundary and whether the pointer returns to set 0.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BEAT,
    ST_MREQ,
    ST_OUT
  } eng_state_e;

  localparam logic [1:0] SEL_CTRL    = 2'd2;
  localparam int         CMD_START   = 0;
  localparam int         CTRL_EN     = 0;
  localparam int         CTRL_DIR    = 1;
endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              ptr,
  input  logic              adv,
  input  logic              done,
  input  logic              abort,
  output logic              en,
  output logic              dir,
  output logic [1:0]        armed,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  cur_len,
  output logic              irq
);
  localparam logic [LEN_W-1:0]  STEP_LEN  = LEN_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(BEAT_BYTES);

  logic [1:0] sel, field;
  logic       aligned;
  assign sel     = reg_addr[5:4];
  assign field   = reg_addr[3:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  logic [1:0][ADDR_W-1:0] addr_v;
  logic [1:0][LEN_W-1:0]  len_v;
  logic [1:0][31:0]       cmd_v;

  for (genvar s = 0; s < 2; s++) begin : g_set
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [31:0]       cmd_q;
    logic              own, wr_ok;
    assign own   = (ptr == 1'(s));
    assign wr_ok = reg_we && aligned && (sel == 2'(s)) && !(busy && own);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= '0;
        len_q  <= '0;
        cmd_q  <= '0;
      end else begin
        if (adv && own) begin
          addr_q <= addr_q + STEP_ADDR;
          len_q  <= (len_q > STEP_LEN) ? len_q - STEP_LEN : '0;
        end else if (wr_ok && field == 2'd0) begin
          addr_q <= reg_wdata[ADDR_W-1:0];
        end else if (wr_ok && field == 2'd1) begin
          len_q <= reg_wdata[LEN_W-1:0];
        end
        if ((done || abort) && own) begin
          cmd_q[CMD_START] <= 1'b0;
        end else if (wr_ok && field == 2'd2) begin
          cmd_q <= reg_wdata;
        end
      end
    end

    assign addr_v[s] = addr_q;
    assign len_v[s]  = len_q;
    assign cmd_v[s]  = cmd_q;
    assign armed[s]  = cmd_q[CMD_START];
  end

  assign cur_addr = addr_v[ptr];
  assign cur_len  = len_v[ptr];

  logic en_q, dir_q, irq_q, last_q;
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = reg_we && aligned && (sel == SEL_CTRL) && (field == 2'd0);
  assign stat_wr = reg_we && aligned && (sel == SEL_CTRL) && (field == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      irq_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata[CTRL_EN];
        dir_q <= reg_wdata[CTRL_DIR];
      end
      if (done) begin
        irq_q  <= 1'b1;
        last_q <= ptr;
      end else if (stat_wr && reg_wdata[0]) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign en  = en_q;
  assign dir = dir_q;
  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (sel < 2'd2) begin
        case (field)
          2'd0:    reg_rdata = 32'(addr_v[sel[0]]);
          2'd1:    reg_rdata = 32'(len_v[sel[0]]);
          2'd2:    reg_rdata = cmd_v[sel[0]];
          default: reg_rdata = '0;
        endcase
      end else if (sel == SEL_CTRL) begin
        case (field)
          2'd0:    reg_rdata = {30'd0, dir_q, en_q};
          2'd1:    reg_rdata = {28'd0, busy, ptr, last_q, irq_q};
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !armed[$past(ptr)]);  // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq);  // R6
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_W     = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dir,
  input  logic [1:0]        armed,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  cur_len,
  output logic              ptr,
  output logic              busy,
  output logic              adv,
  output logic              done,
  output logic              abort,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [LEN_W-1:0] STEP_LEN = LEN_W'(BEAT_BYTES);

  eng_state_e        st;
  logic              ptr_q, dir_q, last_q;
  logic [DATA_W-1:0] hold_q;
  logic              last_now;

  assign last_now = (cur_len <= STEP_LEN);

  always_comb begin
    done  = 1'b0;
    abort = 1'b0;
    adv   = 1'b0;
    case (st)
      ST_IDLE: done  = en && armed[ptr_q] && (cur_len == '0);
      ST_BEAT: abort = !en;
      ST_MREQ: begin
        adv  = mem_gnt;
        done = mem_gnt && dir_q && last_now;
      end
      ST_OUT:  done = out_ready && last_q;
      default: ;
    endcase
  end

  assign ptr       = ptr_q;
  assign busy      = (st != ST_IDLE);
  assign in_ready  = (st == ST_BEAT) && en && dir_q;
  assign mem_req   = (st == ST_MREQ);
  assign mem_we    = dir_q;
  assign mem_addr  = cur_addr;
  assign mem_wdata = hold_q;
  assign out_valid = (st == ST_OUT);
  assign out_data  = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ptr_q  <= 1'b0;
      dir_q  <= 1'b0;
      last_q <= 1'b0;
      hold_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!en) begin
            ptr_q <= 1'b0;
          end else if (armed[ptr_q]) begin
            if (cur_len == '0) begin
              ptr_q <= !ptr_q;
            end else begin
              dir_q <= dir;
              st    <= ST_BEAT;
            end
          end else if (armed[!ptr_q]) begin
            ptr_q <= !ptr_q;
          end
        end
        ST_BEAT: begin
          if (!en) begin
            ptr_q <= 1'b0;
            st    <= ST_IDLE;
          end else if (!dir_q) begin
            st <= ST_MREQ;
          end else if (in_valid) begin
            hold_q <= in_data;
            st     <= ST_MREQ;
          end
        end
        ST_MREQ: begin
          if (mem_gnt) begin
            last_q <= last_now;
            if (dir_q) begin
              if (last_now) begin
                ptr_q <= !ptr_q;
                st    <= ST_IDLE;
              end else begin
                st <= ST_BEAT;
              end
            end else begin
              hold_q <= mem_rdata;
              st     <= ST_OUT;
            end
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            if (last_q) begin
              ptr_q <= !ptr_q;
              st    <= ST_IDLE;
            end else begin
              st <= ST_BEAT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));  // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));  // R3
  AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ptr != $past(ptr));  // R7
  AST_ABORT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !ptr && !busy && !mem_req);  // R10
endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int ADDR_W     = 32;
  localparam int BEAT_BYTES = DATA_W / 8;

  logic              en, dir, busy, ptr, adv, done, abort;
  logic [1:0]        armed;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;

  pp_dma_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .ptr(ptr), .adv(adv), .done(done), .abort(abort),
    .en(en), .dir(dir), .armed(armed), .cur_addr(cur_addr), .cur_len(cur_len),
    .irq(irq)
  );

  pp_dma_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .en(en), .dir(dir), .armed(armed), .cur_addr(cur_addr), .cur_len(cur_len),
    .ptr(ptr), .busy(busy), .adv(adv), .done(done), .abort(abort),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: tb/pingpong_dma_bench.sv
module pingpong_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we, in_ready, out_valid;
  logic [31:0] mem_addr, mem_wdata, out_data;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b0;

  pingpong_dma u_pingpong_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int gnt_mode = 0;
  int sink_mode = 0;
  int src_idx = 0;
  int src_n = 0;
  int gcnt = 0;
  int ocnt = 0;
  logic [31:0] g_addr [64];
  logic [31:0] g_data [64];
  logic        g_we   [64];
  logic [31:0] o_data [64];

  function automatic logic [31:0] mem_pat(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  // memory responder, output sink and input source, all driven at negedge
  initial begin
    logic tog;
    tog = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_gnt = 1'b0;
      if (mem_req) begin
        tog = !tog;
        if (gnt_mode == 0 || tog) begin
          mem_gnt   = 1'b1;
          mem_rdata = mem_pat(mem_addr);
          g_addr[gcnt % 64] = mem_addr;
          g_data[gcnt % 64] = mem_we ? mem_wdata : mem_pat(mem_addr);
          g_we[gcnt % 64]   = mem_we;
          gcnt++;
        end
      end
      out_ready = (sink_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (out_valid && out_ready) begin
        o_data[ocnt % 64] = out_data;
        ocnt++;
      end
      in_valid = (src_idx < src_n);
      in_data  = 32'hD000_0000 + 32'(src_idx);
      if (in_valid && in_ready) src_idx++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s, c0, c1;
    for (int i = 0; i < 2000; i++) begin
      rd(6'h24, s); rd(6'h08, c0); rd(6'h18, c1);
      if (!s[3] && !c0[0] && !c1[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 irq", 32'(irq), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 in_ready", 32'(in_ready), 0);
    check("R1 out_valid", 32'(out_valid), 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(6'h00, 32'h1234_5678); rd(6'h00, v); check("R2 set0 addr", v, 32'h1234_5678);
    wr(6'h14, 32'h0000_ABCD); rd(6'h14, v); check("R2 set1 len", v, 32'h0000_ABCD);
    wr(6'h18, 32'h0000_0F00); rd(6'h18, v); check("R2 set1 cmd", v, 32'h0000_0F00);
    wr(6'h20, 32'h2);         rd(6'h20, v); check("R2 ctrl dir", v, 32'h2);
    wr(6'h20, 32'h0); wr(6'h18, 32'h0);
  endtask

  task automatic t_no_arm();
    int g0;
    g0 = gcnt;
    wr(6'h20, 32'h1);
    repeat (10) @(negedge clk);
    check("R8 no request without armed set", 32'(gcnt - g0), 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int g0, o0;
    g0 = gcnt; o0 = ocnt;
    gnt_mode = 1; sink_mode = 1;
    wr(6'h00, 32'h0000_1000); wr(6'h04, 32'd16); wr(6'h08, 32'h1);
    wait_idle();
    check("R5 beat count", 32'(gcnt - g0), 4);
    check("R3 output count", 32'(ocnt - o0), 4);
    for (int i = 0; i < 4; i++) begin
      check("R5 read address", g_addr[(g0 + i) % 64], 32'h1000 + 32'(4 * i));
      check("R3 output data", o_data[(o0 + i) % 64], mem_pat(32'h1000 + 32'(4 * i)));
    end
    rd(6'h00, v); check("R5 final addr", v, 32'h1010);
    rd(6'h04, v); check("R5 final len", v, 32'h0);
    rd(6'h08, v); check("R6 start cleared", v, 32'h0);
    check("R6 irq high", 32'(irq), 1);
    rd(6'h24, v); check("R6 R7 status (irq, last 0, ptr 1)", v, 32'h5);
    wr(6'h24, 32'h1);
    rd(6'h24, v); check("R6 flag cleared by write 1", v, 32'h4);
    check("R6 irq low", 32'(irq), 0);
  endtask

  task automatic t_skip();
    logic [31:0] v;
    int g0;
    g0 = gcnt;
    gnt_mode = 0; sink_mode = 0;
    wr(6'h00, 32'h0000_2000); wr(6'h04, 32'd8); wr(6'h08, 32'h1);
    wait_idle();
    check("R8 skipped to set0 beats", 32'(gcnt - g0), 2);
    check("R8 skipped to set0 addr", g_addr[g0 % 64], 32'h2000);
    rd(6'h24, v); check("R8 status after skip", v, 32'h5);
    wr(6'h24, 32'h1);
  endtask

  task automatic t_backtoback();
    logic [31:0] v;
    int g0, s0;
    g0 = gcnt; s0 = src_idx;
    gnt_mode = 1;
    wr(6'h20, 32'h3);
    wr(6'h10, 32'h0000_3000); wr(6'h14, 32'd8);
    wr(6'h00, 32'h0000_4000); wr(6'h04, 32'd12);
    wr(6'h18, 32'h1); wr(6'h08, 32'h1);
    src_n = s0 + 5;
    wait_idle();
    check("R7 total beats over both sets", 32'(gcnt - g0), 5);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] ea;
      ea = (i < 2) ? 32'h3000 + 32'(4 * i) : 32'h4000 + 32'(4 * (i - 2));
      check("R7 write address order", g_addr[(g0 + i) % 64], ea);
      check("R4 write data", g_data[(g0 + i) % 64], 32'hD000_0000 + 32'(s0 + i));
      check("R4 write strobe", 32'(g_we[(g0 + i) % 64]), 1);
    end
    rd(6'h24, v); check("R7 status after both sets", v, 32'h5);
    wr(6'h24, 32'h1);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    int g0, s0;
    g0 = gcnt; s0 = src_idx;
    wr(6'h10, 32'h0000_5000); wr(6'h14, 32'd4); wr(6'h18, 32'h1);
    repeat (3) @(negedge clk);
    wr(6'h10, 32'h0000_9000); rd(6'h10, v); check("R9 active addr write ignored", v, 32'h5000);
    wr(6'h14, 32'd64);        rd(6'h14, v); check("R9 active len write ignored", v, 32'd4);
    wr(6'h18, 32'h0);         rd(6'h18, v); check("R9 active cmd write ignored", v, 32'h1);
    wr(6'h00, 32'h0000_6000); rd(6'h00, v); check("R9 idle set write taken", v, 32'h6000);
    src_n = s0 + 1;
    wait_idle();
    check("R9 single beat", 32'(gcnt - g0), 1);
    check("R9 beat at original addr", g_addr[g0 % 64], 32'h5000);
    rd(6'h24, v); check("R6 status last set 1", v, 32'h3);
    wr(6'h24, 32'h1);
  endtask

  task automatic t_zero_len();
    logic [31:0] v;
    int g0;
    g0 = gcnt;
    wr(6'h20, 32'h1);
    wr(6'h04, 32'd0); wr(6'h08, 32'h1);
    repeat (5) @(negedge clk);
    check("R11 no request for zero length", 32'(gcnt - g0), 0);
    rd(6'h08, v); check("R11 start cleared", v, 32'h0);
    rd(6'h24, v); check("R11 completion status", v, 32'h5);
    wr(6'h24, 32'h1);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int g0, n;
    g0 = gcnt;
    gnt_mode = 0; sink_mode = 0;
    wr(6'h10, 32'h0000_7000); wr(6'h14, 32'd64); wr(6'h18, 32'h1);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (gcnt - g0 >= 3) break;
    end
    wr(6'h20, 32'h0);
    repeat (20) @(negedge clk);
    n = gcnt - g0;
    check("R10 beats stop at boundary", 32'(n >= 3 && n <= 4), 1);
    for (int i = 0; i < 3; i++)
      check("R10 beat addresses", g_addr[(g0 + i) % 64], 32'h7000 + 32'(4 * i));
    check("R10 no request after abort", 32'(mem_req), 0);
    rd(6'h18, v); check("R10 start cleared", v, 32'h0);
    rd(6'h24, v); check("R10 status ptr 0, no irq", v, 32'h0);
    check("R10 irq low", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_no_arm();
    t_read();
    t_skip();
    t_backtoback();
    t_ignore();
    t_zero_len();
    t_abort();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule